// File: doc/BRIEF.md
# Shared-Threshold Pin Debounce Filter

This block cleans up the eight input levels of one GPIO port before they reach the input register and the edge/level interrupt detector. The pins arrive already synchronized to the system clock. One 8-bit threshold, counted in millisecond ticks, is shared by the whole port. Each pin has its own enable bit. An enabled pin moves its filtered level to a new raw level only once that level has held for the programmed number of ticks. A disabled pin, or any pin while the threshold is zero, passes its raw level through after one register stage.

The enable bits are written in a masked format. A single write can set or clear any subset of pins without a read-modify-write. Each pin has a three-state machine: `ST_SEED`, `ST_STABLE` and `ST_COUNT`. Reset enters `ST_SEED`. At the first clock after reset, transition *seed* loads the raw level and moves to `ST_STABLE`. In `ST_STABLE`, the transitions are:
- *pass*: bypass is active and the level differs, so the pin copies the raw level and stays in `ST_STABLE`.
- *start*: the first tick arrives while the level differs, so the count becomes 1 and the pin moves to `ST_COUNT`. When the threshold is 1, *commit* fires at once instead.

In `ST_COUNT`, the transitions are:
- *commit*: a tick brings the count up to the threshold.
- *abort*: the raw level returns to the filtered level.
- *release*: bypass becomes active.

All three return the pin to `ST_STABLE`. An ordinary tick below the threshold advances the count and stays in `ST_COUNT`. The 1 ms tick pulse is generated outside the block.

Top module: `port_debounce`

## Requirements
- R1: During reset, filt_o, en_o and lim_o are all zero. At the first rising clock edge after reset is released, filt_o takes the pin_i value present at that edge.
- R2: A write with en_we_i high updates enable bit n to en_wdata_i[n] only when mask bit en_wdata_i[8+n] is 1. Enable bits whose mask bit is 0 keep their value. The new enables are visible on en_o one cycle after the write.
- R3: A write with lim_we_i high loads the 8-bit tick threshold from lim_wdata_i into lim_o one cycle later. All eight pins use this one threshold.
- R4: When a pin's enable bit is 0, its filt_o bit equals the pin_i bit from the previous clock edge.
- R5: When the threshold is 0, an enabled pin behaves exactly as in R4.
- R6: When a pin is enabled with threshold N>0, its filt_o bit takes a differing raw level on the edge of the N-th tick counted while the raw level keeps differing. The tick in the first differing cycle counts, so N=1 commits on that tick.
- R7: If the raw level returns to the filtered level before the N-th tick, the accumulated count is discarded and filt_o does not change. A later disagreement starts counting from zero.
- R8: For an enabled pin with a nonzero threshold, filt_o changes only on an edge where tick_i is high.
- R9: The threshold is re-read at every tick. If it is lowered to or below the count already reached, the pin commits at the next tick.
- R10: Each pin keeps its own count. Activity on one pin never moves another pin's filt_o.
- R11: Clearing a counting pin's enable bit makes its filt_o take the raw level at the next edge. The count is dropped.
- R12: The maximum threshold of 255 takes exactly 255 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Synchronized raw pin levels |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| en_we_i | input | 1 | Masked enable write strobe |
| en_wdata_i | input | 16 | Mask in [15:8], values in [7:0] |
| lim_we_i | input | 1 | Threshold write strobe |
| lim_wdata_i | input | 8 | New tick threshold |
| filt_o | output | 8 | Filtered pin levels |
| en_o | output | 8 | Current per-pin enable bits |
| lim_o | output | 8 | Current shared threshold |

## Verification
Directed sequences cover several cases in turn:
- A raw flip held for the full threshold, which separates committing on the N-th tick from committing one tick early or late.
- A flip that returns before the threshold, which separates a count that is discarded from one that is merely paused.
- Lowering the threshold mid-count, which separates re-reading the threshold from latching it at the start.
- Disabling a pin mid-count.
- The 255 threshold.

Seeded random runs then mix per-pin enables, small thresholds, sparse raw toggles and irregular ticks. A wrong shared-counter structure, or pins that influence one another, produces mismatches against the per-pin reference model.

// File: rtl/port_debounce_pkg.sv
package port_debounce_pkg;

    typedef enum logic [1:0] {
        ST_SEED   = 2'd0,
        ST_STABLE = 2'd1,
        ST_COUNT  = 2'd2
    } dbn_state_e;

endpackage

// File: rtl/dbn_cfg_regs.sv
module dbn_cfg_regs #(
    parameter int PINS  = 8,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we_i,
    input  logic [2*PINS-1:0]  en_wdata_i,
    input  logic               lim_we_i,
    input  logic [CNT_W-1:0]   lim_wdata_i,
    output logic [PINS-1:0]    en_q_o,
    output logic [CNT_W-1:0]   lim_q_o
);

    localparam int MASK_LSB = PINS;

    // masked enable bits: one flop per pin, written only under its mask bit
    for (genvar g = 0; g < PINS; g++) begin : g_en_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q_o[g] <= 1'b0;
            end else if (en_we_i && en_wdata_i[MASK_LSB + g]) begin
                en_q_o[g] <= en_wdata_i[g];
            end
        end
    end

    // single threshold shared by the whole port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q_o <= '0;
        end else if (lim_we_i) begin
            lim_q_o <= lim_wdata_i;
        end
    end

endmodule

// File: rtl/dbn_pin_fsm.sv
module dbn_pin_fsm
    import port_debounce_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  limit_i,
    output logic              filt_o
);

    localparam int EXT_W = CNT_W + 1;

    dbn_state_e       state_q, state_d;
    logic             filt_q, filt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             differs;
    logic             bypass;
    logic [EXT_W-1:0] cnt_inc;
    logic             at_limit;

    assign differs  = raw_i ^ filt_q;
    assign bypass   = !en_i || (limit_i == '0);
    assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign at_limit = cnt_inc >= {1'b0, limit_i};

    // next-state and next-value logic
    always_comb begin
        state_d = state_q;
        filt_d  = filt_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SEED: begin
                filt_d  = raw_i;
                cnt_d   = '0;
                state_d = ST_STABLE;
            end
            ST_STABLE: begin
                if (differs) begin
                    if (bypass) begin
                        filt_d = raw_i;
                    end else if (tick_i) begin
                        if (at_limit) begin
                            filt_d = raw_i;
                        end else begin
                            cnt_d   = cnt_inc[CNT_W-1:0];
                            state_d = ST_COUNT;
                        end
                    end
                end
            end
            ST_COUNT: begin
                if (bypass) begin
                    filt_d  = raw_i;
                    cnt_d   = '0;
                    state_d = ST_STABLE;
                end else if (!differs) begin
                    cnt_d   = '0;
                    state_d = ST_STABLE;
                end else if (tick_i) begin
                    if (at_limit) begin
                        filt_d  = raw_i;
                        cnt_d   = '0;
                        state_d = ST_STABLE;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                state_d = ST_SEED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // output and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            filt_q <= filt_d;
            cnt_q  <= cnt_d;
        end
    end

    assign filt_o = filt_q;

endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
    parameter int PINS  = 8,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PINS-1:0]    pin_i,
    input  logic               tick_i,
    input  logic               en_we_i,
    input  logic [2*PINS-1:0]  en_wdata_i,
    input  logic               lim_we_i,
    input  logic [CNT_W-1:0]   lim_wdata_i,
    output logic [PINS-1:0]    filt_o,
    output logic [PINS-1:0]    en_o,
    output logic [CNT_W-1:0]   lim_o
);

    logic [PINS-1:0]  en_q;
    logic [CNT_W-1:0] lim_q;

    dbn_cfg_regs #(
        .PINS  (PINS),
        .CNT_W (CNT_W)
    ) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_we_i     (en_we_i),
        .en_wdata_i  (en_wdata_i),
        .lim_we_i    (lim_we_i),
        .lim_wdata_i (lim_wdata_i),
        .en_q_o      (en_q),
        .lim_q_o     (lim_q)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        dbn_pin_fsm #(
            .CNT_W (CNT_W)
        ) fsm_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (pin_i[g]),
            .tick_i  (tick_i),
            .en_i    (en_q[g]),
            .limit_i (lim_q),
            .filt_o  (filt_o[g])
        );
    end

    assign en_o  = en_q;
    assign lim_o = lim_q;

endmodule

// File: rtl/port_debounce_chk.sv
module port_debounce_chk #(
    parameter int PINS  = 8,
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PINS-1:0]    pin_i,
    input logic               tick_i,
    input logic               en_we_i,
    input logic [2*PINS-1:0]  en_wdata_i,
    input logic               lim_we_i,
    input logic [CNT_W-1:0]   lim_wdata_i,
    input logic [PINS-1:0]    filt_o,
    input logic [PINS-1:0]    en_o,
    input logic [CNT_W-1:0]   lim_o
);

    assert_limit_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lim_we_i |=> (lim_o == $past(lim_wdata_i)));

    assert_limit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_we_i |=> $stable(lim_o));

    for (genvar g = 0; g < PINS; g++) begin : g_pin_chk
        assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (en_we_i && en_wdata_i[PINS + g]) |=> (en_o[g] == $past(en_wdata_i[g])));

        assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(en_we_i && en_wdata_i[PINS + g]) |=> $stable(en_o[g]));

        // also covers R5 (threshold zero acts as bypass)
        assert_bypass_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_o[g] || (lim_o == '0)) |=> (filt_o[g] == $past(pin_i[g])));

        assert_step_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_o[g] && (lim_o != '0) && !tick_i) |=> $stable(filt_o[g]));

        assert_move_to_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_o[g] != $past(filt_o[g])) |-> (filt_o[g] == $past(pin_i[g])));

        assert_unit_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_o[g] && (lim_o == 1) && tick_i && (pin_i[g] != filt_o[g]))
            |=> (filt_o[g] == $past(pin_i[g])));
    end

endmodule

bind port_debounce port_debounce_chk #(
    .PINS  (PINS),
    .CNT_W (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .tick_i      (tick_i),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .lim_we_i    (lim_we_i),
    .lim_wdata_i (lim_wdata_i),
    .filt_o      (filt_o),
    .en_o        (en_o),
    .lim_o       (lim_o)
);

// File: tb/port_debounce_tb_top.sv
`timescale 1ns/1ps
module port_debounce_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = 8'h00;
    logic        tick = 1'b0;
    logic        en_we = 1'b0;
    logic [15:0] en_wdata = 16'h0;
    logic        lim_we = 1'b0;
    logic [7:0]  lim_wdata = 8'h0;
    logic [7:0]  filt, en_rd, lim_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // reference state
    logic [7:0] m_filt;
    logic [7:0] m_en;
    logic [7:0] m_lim;
    int         m_cnt [8];
    bit         m_seed;

    always #2 clk = ~clk;

    port_debounce dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .tick_i      (tick),
        .en_we_i     (en_we),
        .en_wdata_i  (en_wdata),
        .lim_we_i    (lim_we),
        .lim_wdata_i (lim_wdata),
        .filt_o      (filt),
        .en_o        (en_rd),
        .lim_o       (lim_rd)
    );

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        if (m_seed) begin
            m_filt = pin;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
            m_seed = 1'b0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (!m_en[i] || m_lim == 8'd0) begin
                    m_filt[i] = pin[i];
                    m_cnt[i]  = 0;
                end else if (pin[i] == m_filt[i]) begin
                    m_cnt[i] = 0;
                end else if (tick) begin
                    if (m_cnt[i] + 1 >= int'(m_lim)) begin
                        m_filt[i] = pin[i];
                        m_cnt[i]  = 0;
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                    end
                end
            end
        end
        if (en_we) m_en = (m_en & ~en_wdata[15:8]) | (en_wdata[7:0] & en_wdata[15:8]);
        if (lim_we) m_lim = lim_wdata;
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check8(cur_req, "filt_o", filt, m_filt);
        check8(cur_req, "en_o", en_rd, m_en);
        check8(cur_req, "lim_o", lim_rd, m_lim);
    endtask

    task automatic idle(int n, int tick_every);
        for (int k = 0; k < n; k++) begin
            tick = (tick_every > 0) && (k % tick_every == tick_every - 1);
            step();
        end
        tick = 1'b0;
    endtask

    task automatic wr_en(logic [7:0] mask, logic [7:0] val);
        en_we = 1'b1;
        en_wdata = {mask, val};
        step();
        en_we = 1'b0;
    endtask

    task automatic wr_lim(logic [7:0] v);
        lim_we = 1'b1;
        lim_wdata = v;
        step();
        lim_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        m_filt = 8'h00; m_en = 8'h00; m_lim = 8'h00; m_seed = 1'b1;
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;

        // R1: reset values, then seed from raw
        pin = 8'hA5;
        repeat (3) @(negedge clk);
        check8("R1", "filt_o in reset", filt, 8'h00);
        check8("R1", "en_o in reset", en_rd, 8'h00);
        check8("R1", "lim_o in reset", lim_rd, 8'h00);
        rst_n = 1'b1;
        cur_req = "R1";
        step();
        check8("R1", "filt_o seeded", filt, 8'hA5);

        // R4: disabled pins pass raw levels
        cur_req = "R4";
        for (int k = 0; k < 20; k++) begin
            pin = 8'($urandom);
            tick = ($urandom % 3) == 0;
            step();
        end
        tick = 1'b0;

        // R2: masked enable writes
        cur_req = "R2";
        wr_en(8'h0F, 8'h05);
        check8("R2", "en after low-nibble write", en_rd, 8'h05);
        wr_en(8'hF0, 8'hFA);
        check8("R2", "en after high-nibble write", en_rd, 8'hF5);
        wr_en(8'h00, 8'hFF);
        check8("R2", "en with empty mask", en_rd, 8'hF5);
        wr_en(8'hFF, 8'hFF);

        // R5: enabled but threshold zero
        cur_req = "R5";
        for (int k = 0; k < 20; k++) begin
            pin = 8'($urandom);
            tick = ($urandom % 2) == 0;
            step();
        end
        tick = 1'b0;

        // R3 / R6: threshold 3, flip pin 0, commit on third tick
        cur_req = "R3";
        wr_lim(8'd3);
        check8("R3", "lim_o", lim_rd, 8'd3);
        cur_req = "R6";
        pin = pin ^ 8'h01;
        idle(5, 2);
        check8("R6", "pin0 held after two ticks", filt ^ pin, 8'h01);
        idle(2, 2);
        check8("R6", "pin0 committed on third tick", filt ^ pin, 8'h00);

        // R7: glitch shorter than threshold
        cur_req = "R7";
        wr_lim(8'd4);
        pin = pin ^ 8'h02;
        idle(6, 2);
        pin = pin ^ 8'h02;
        idle(4, 2);
        pin = pin ^ 8'h02;
        idle(6, 2);
        check8("R7", "pin1 count restarted", filt ^ pin, 8'h02);
        idle(2, 2);

        // R9: lower threshold mid-count
        cur_req = "R9";
        wr_lim(8'd6);
        pin = pin ^ 8'h04;
        idle(8, 2);
        wr_lim(8'd2);
        idle(2, 2);
        check8("R9", "pin2 commit after lowering", filt ^ pin, 8'h00);

        // R11: disable mid-count
        cur_req = "R11";
        wr_lim(8'd10);
        pin = pin ^ 8'h08;
        idle(6, 2);
        wr_en(8'h08, 8'h00);
        step();
        check8("R11", "pin3 released", filt ^ pin, 8'h00);
        wr_en(8'h08, 8'h08);

        // R12: maximum threshold
        cur_req = "R12";
        wr_lim(8'd255);
        pin = pin ^ 8'h10;
        idle(508, 2);
        check8("R12", "pin4 still held at 254 ticks", filt ^ pin, 8'h10);
        idle(2, 2);
        check8("R12", "pin4 committed at 255 ticks", filt ^ pin, 8'h00);

        // R10 / R8: random mix
        cur_req = "R10";
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 8) == 0) pin = pin ^ (8'h01 << ($urandom % 8));
            tick = ($urandom % 3) == 0;
            if (($urandom % 200) == 0) begin
                en_we = 1'b1;
                en_wdata = 16'($urandom);
            end
            if (($urandom % 250) == 0) begin
                lim_we = 1'b1;
                lim_wdata = 8'($urandom % 6);
            end
            if (k == 1500) cur_req = "R8";
            step();
            en_we = 1'b0;
            lim_we = 1'b0;
        end
        tick = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule